// File: doc/BRIEF.md
# Threshold-Limited Multi-Class Packet Queue

This block holds packet descriptors in several priority buffers and is the queueing stage that follows a flow classifier. Buffer 0 has the highest service priority and buffer M the lowest. All buffers live in one ordered store, laid end to end in priority order, so each buffer is a contiguous slice of the store. A boundary counter per buffer marks where each slice ends. Every descriptor counts as one unit of occupancy, whatever the size of its packet.

Limits apply to cumulative occupancy. Q_i is the number of descriptors held in buffers 0 through i, and its limit is K_i = KSTEP*(i+1). With the defaults (three buffers, KSTEP = 6) the limits are 6, 12 and 18.

Traffic moves between neighbouring buffers in three ways:
- An arrival that finds its own level full falls to the next lower buffer.
- An admission that fills a lower level pushes the last descriptor of that level down into the next buffer.
- An external credit unit requests promotions. A promotion moves the head of a buffer up into the buffer above.

None of these moves copies data: only the boundary counters shift. The output is a strict-priority dequeue port. For each arrival the block reports which classes were violated, whether a descriptor was dropped, and whether the arrival went straight into its own class buffer.

Top module: `fsq_engine`

## Requirements
- R1: During and after reset the store is empty: deq_valid, adm_valid, drop and every viol bit are low.
- R2: A class-c arrival is appended to the tail of buffer c when Q_c < K_c. A class field value above M is treated as M.
- R3: When Q_c = K_c, the arrival goes to the tail of the first lower-priority buffer t whose Q_t < K_t. Bit j of viol is set for every level j from c to t-1 that was skipped.
- R4: Suppose an arrival is admitted to buffer t. Then for every j > t whose Q_j was already at K_j, the last descriptor of buffer j becomes the head of buffer j+1, and bit j of viol is set.
- R5: The drop flag is raised when an arrival finds no level with room (viol bits c..M set), or when a push-out leaves buffer M. The descriptor concerned is discarded.
- R6: promo_req bit i asks for a move from buffer i to buffer i-1. The request is held until it can be served. When buffer i is not empty and Q_{i-1} < K_{i-1}, the head of buffer i moves to the tail of buffer i-1. This is allowed even when Q_i = K_i.
- R7: deq_data is the head of the first non-empty buffer, and deq_class is that buffer's index. Each buffer is first-in first-out, and a dequeue happens when deq_valid and deq_ready are both high.
- R8: Within one cycle, events are applied in a fixed order: the arrival, then push-outs, then promotions, then the dequeue. The dequeue removes exactly the descriptor that was presented in that cycle.
- R9: adm_valid pulses one cycle after an arrival that entered its own class buffer directly, and adm_class then gives that class. viol and drop are likewise one-cycle pulses, registered one cycle after the arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | An arriving descriptor is present |
| arr_class | input | CLW | Class tag of the arrival |
| arr_data | input | DW | Descriptor value |
| promo_req | input | NCLS-1 | Bit i requests a move from buffer i to buffer i-1 |
| deq_ready | input | 1 | Consumer takes the presented descriptor |
| deq_valid | output | 1 | Store is non-empty |
| deq_data | output | DW | Head descriptor of the highest non-empty buffer |
| deq_class | output | CLW | Buffer index of the presented descriptor |
| adm_valid | output | 1 | Arrival entered its own class buffer |
| adm_class | output | CLW | Class of that admission |
| viol | output | NCLS | Per-class violation pulses |
| drop | output | 1 | A descriptor was discarded |

## Verification
The hardest state to reach from the ports is one where several levels sit exactly at their limits at the same moment. In that state a single arrival both pushes out descriptors and meets deferred promotions and a dequeue in the same cycle. The stimulus gets there in two ways. Directed bursts fill levels to their limits without draining. Random phases then alternate between filling, with sparse dequeues, and draining, with frequent dequeues, while promotion requests arrive throughout. A model of separate per-buffer FIFOs, which tracks each descriptor by its own identity, predicts every output.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    // cumulative occupancy limit for levels 0..idx
    function automatic int unsigned fsq_limit(input int unsigned idx, input int unsigned step);
        return step * (idx + 1);
    endfunction
endpackage

// File: rtl/fsq_admit.sv
module fsq_admit
    import fsq_pkg::*;
#(
    parameter int NCLS  = 3,
    parameter int KSTEP = 6,
    parameter int CW    = 5,
    parameter int CLW   = 2
) (
    input  logic                      arr_valid,
    input  logic [CLW-1:0]            cls,
    input  logic [NCLS-1:0][CW-1:0]   cum,
    output logic                      ins_en,
    output logic [CLW-1:0]            ins_buf,
    output logic [CW-1:0]             ins_pos,
    output logic [NCLS-1:0]           po_vec,
    output logic [NCLS-1:0]           viol_vec,
    output logic                      drop_now,
    output logic                      adm_now
);
    logic            found;
    logic [CLW-1:0]  tgt;
    logic [NCLS-1:0] skip;

    // search for the first level at or below the class with room
    always_comb begin
        found = 1'b0;
        tgt   = '0;
        skip  = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (arr_valid && !found && i >= int'(cls)) begin
                if (cum[i] < CW'(fsq_limit(i, KSTEP))) begin
                    found = 1'b1;
                    tgt   = CLW'(i);
                end else begin
                    skip[i] = 1'b1;
                end
            end
        end
    end

    // levels below the target that are at their limit push out
    always_comb begin
        ins_en  = arr_valid && found;
        ins_buf = tgt;
        ins_pos = cum[tgt];
        for (int j = 0; j < NCLS; j++) begin
            po_vec[j] = ins_en && (j > int'(tgt)) && (cum[j] == CW'(fsq_limit(j, KSTEP)));
        end
        viol_vec = skip | po_vec;
        drop_now = (arr_valid && !found) || po_vec[NCLS-1];
        adm_now  = ins_en && (tgt == cls);
    end
endmodule

// File: rtl/fsq_promote.sv
module fsq_promote
    import fsq_pkg::*;
#(
    parameter int NCLS  = 3,
    parameter int KSTEP = 6,
    parameter int CW    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCLS-1:0]           req,
    input  logic [NCLS-1:0][CW-1:0]   cnt_a,
    input  logic [NCLS-1:0][CW-1:0]   cum_a,
    output logic [NCLS-1:0]           grant
);
    localparam logic [NCLS-1:0] VALID_MASK = {{(NCLS-1){1'b1}}, 1'b0};

    logic [NCLS-1:0] pend_q;
    logic [NCLS-1:0] want;

    always_comb begin
        want  = (pend_q | req) & VALID_MASK;
        grant = '0;
        for (int i = 1; i < NCLS; i++) begin
            grant[i] = want[i] && (cnt_a[i] != '0) &&
                       (cum_a[i-1] < CW'(fsq_limit(i - 1, KSTEP)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= want & ~grant;
    end
endmodule

// File: rtl/fsq_store.sv
module fsq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 18,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  logic [CW-1:0] ins_pos,
    input  logic [DW-1:0] ins_data,
    input  logic          rem_en,
    input  logic [CW-1:0] rem_pos,
    output logic [DW-1:0] head
);
    // one spare slot on top keeps the shift loops in range
    logic [DW-1:0] mem_q [DEPTH+1];
    logic [DW-1:0] ext   [DEPTH+1];
    logic [DW-1:0] nxt   [DEPTH+1];

    always_comb begin
        for (int k = 0; k <= DEPTH; k++) begin
            if (!ins_en || CW'(k) < ins_pos)
                ext[k] = mem_q[k];
            else if (CW'(k) == ins_pos)
                ext[k] = ins_data;
            else
                ext[k] = mem_q[(k > 0) ? k - 1 : 0];
        end
        for (int k = 0; k < DEPTH; k++) begin
            nxt[k] = (rem_en && CW'(k) >= rem_pos) ? ext[k+1] : ext[k];
        end
        nxt[DEPTH] = '0;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k <= DEPTH; k++) begin
            if (!rst_n) mem_q[k] <= '0;
            else        mem_q[k] <= nxt[k];
        end
    end

    assign head = mem_q[0];
endmodule

// File: rtl/fsq_engine.sv
module fsq_engine
    import fsq_pkg::*;
#(
    parameter int NCLS  = 3,
    parameter int KSTEP = 6,
    parameter int DW    = 8,
    localparam int CLW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arr_valid,
    input  logic [CLW-1:0]  arr_class,
    input  logic [DW-1:0]   arr_data,
    input  logic [NCLS-1:1] promo_req,
    input  logic            deq_ready,
    output logic            deq_valid,
    output logic [DW-1:0]   deq_data,
    output logic [CLW-1:0]  deq_class,
    output logic            adm_valid,
    output logic [CLW-1:0]  adm_class,
    output logic [NCLS-1:0] viol,
    output logic            drop
);
    localparam int DEPTH = KSTEP * NCLS;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef logic [NCLS-1:0][CW-1:0] cvec_t;

    function automatic cvec_t prefix(input cvec_t v);
        cvec_t       r;
        logic [CW-1:0] run;
        run = '0;
        for (int i = 0; i < NCLS; i++) begin
            run  = run + v[i];
            r[i] = run;
        end
        return r;
    endfunction

    cvec_t cnt_q, cum_q, cnt_a, cum_a, cnt_p, cum_p, cnt_n;

    logic [CLW-1:0]  cls_eff;
    logic            ins_en, drop_now, adm_now, fire, rem_hit, cls_hit;
    logic [CLW-1:0]  ins_buf;
    logic [CW-1:0]   ins_pos, rem_pos, total;
    logic [NCLS-1:0] po_vec, po_in, viol_vec, grant, gr_in;

    always_comb cls_eff = (int'(arr_class) >= NCLS) ? CLW'(NCLS - 1) : arr_class;
    always_comb cum_q   = prefix(cnt_q);
    assign total = cum_q[NCLS-1];

    fsq_admit #(.NCLS(NCLS), .KSTEP(KSTEP), .CW(CW), .CLW(CLW)) u_admit (
        .arr_valid (arr_valid),
        .cls       (cls_eff),
        .cum       (cum_q),
        .ins_en    (ins_en),
        .ins_buf   (ins_buf),
        .ins_pos   (ins_pos),
        .po_vec    (po_vec),
        .viol_vec  (viol_vec),
        .drop_now  (drop_now),
        .adm_now   (adm_now)
    );

    // boundaries after admission and push-outs
    assign po_in = {po_vec[NCLS-2:0], 1'b0};
    always_comb begin
        for (int i = 0; i < NCLS; i++) begin
            cnt_a[i] = cnt_q[i] + CW'(ins_en && (ins_buf == CLW'(i)))
                     - CW'(po_vec[i]) + CW'(po_in[i]);
        end
        cum_a = prefix(cnt_a);
    end

    fsq_promote #(.NCLS(NCLS), .KSTEP(KSTEP), .CW(CW)) u_promote (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({promo_req, 1'b0}),
        .cnt_a (cnt_a),
        .cum_a (cum_a),
        .grant (grant)
    );

    // boundaries after promotions
    assign gr_in = {1'b0, grant[NCLS-1:1]};
    always_comb begin
        for (int i = 0; i < NCLS; i++) begin
            cnt_p[i] = cnt_a[i] - CW'(grant[i]) + CW'(gr_in[i]);
        end
        cum_p = prefix(cnt_p);
    end

    // dequeue removes the presented entry, wherever it now sits
    assign deq_valid = (total != '0);
    assign fire      = deq_valid && deq_ready;
    assign rem_pos   = (ins_en && ins_pos == '0 && deq_valid) ? CW'(1) : '0;

    always_comb begin
        rem_hit = 1'b0;
        for (int j = 0; j < NCLS; j++) begin
            cnt_n[j] = cnt_p[j];
            if (fire && !rem_hit && cum_p[j] > rem_pos) begin
                cnt_n[j] = cnt_p[j] - CW'(1);
                rem_hit  = 1'b1;
            end
        end
    end

    always_comb begin
        cls_hit   = 1'b0;
        deq_class = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (!cls_hit && cnt_q[i] != '0) begin
                deq_class = CLW'(i);
                cls_hit   = 1'b1;
            end
        end
    end

    fsq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_en),
        .ins_pos  (ins_pos),
        .ins_data (arr_data),
        .rem_en   (fire),
        .rem_pos  (rem_pos),
        .head     (deq_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            adm_valid <= 1'b0;
            adm_class <= '0;
            viol      <= '0;
            drop      <= 1'b0;
        end else begin
            cnt_q     <= cnt_n;
            adm_valid <= adm_now;
            adm_class <= ins_buf;
            viol      <= viol_vec;
            drop      <= drop_now;
        end
    end

    // cumulative limits are never exceeded
    for (genvar g = 0; g < NCLS; g++) begin : g_lim
        assert_q_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cum_q[g] <= CW'(fsq_limit(g, KSTEP)));
    end

    assert_deq_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_ready && !arr_valid) |=> (total == $past(total) - CW'(1)));

    assert_hold_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_valid && !(deq_valid && deq_ready)) |=> (total == $past(total)));

    assert_drop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> ($past(total) == CW'(DEPTH)));

    assert_adm_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adm_valid |-> (viol[adm_class] == 1'b0));
endmodule

// File: tb/fsq_engine_tb.sv
module fsq_engine_tb;
    localparam int NC = 3;
    localparam int KS = 6;
    localparam int DP = NC * KS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arr_valid = 1'b0;
    logic [1:0]    arr_class = '0;
    logic [7:0]    arr_data = '0;
    logic [NC-1:1] promo_req = '0;
    logic          deq_ready = 1'b0;
    logic          deq_valid;
    logic [7:0]    deq_data;
    logic [1:0]    deq_class;
    logic          adm_valid;
    logic [1:0]    adm_class;
    logic [NC-1:0] viol;
    logic          drop;

    always #10 clk = ~clk;

    fsq_engine #(.NCLS(NC), .KSTEP(KS), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_class(arr_class),
        .arr_data(arr_data), .promo_req(promo_req), .deq_ready(deq_ready),
        .deq_valid(deq_valid), .deq_data(deq_data), .deq_class(deq_class),
        .adm_valid(adm_valid), .adm_class(adm_class), .viol(viol), .drop(drop)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference: separate FIFOs per buffer, entries tagged by identity
    logic [7:0]    md [NC][DP];
    int            mi [NC][DP];
    int            mn [NC];
    logic [NC-1:0] mpend;
    int            next_id;
    logic [NC-1:0] ev_viol;
    bit            ev_drop, ev_adm;
    int            ev_admc;

    function automatic int lim(int i);
        return KS * (i + 1);
    endfunction

    function automatic int mcum(int i);
        int s = 0;
        for (int b = 0; b <= i; b++) s += mn[b];
        return s;
    endfunction

    function automatic int mfirst();
        for (int b = 0; b < NC; b++) if (mn[b] > 0) return b;
        return -1;
    endfunction

    task automatic push_back(int b, logic [7:0] d, int id);
        md[b][mn[b]] = d; mi[b][mn[b]] = id; mn[b]++;
    endtask

    task automatic push_front(int b, logic [7:0] d, int id);
        for (int p = mn[b]; p > 0; p--) begin md[b][p] = md[b][p-1]; mi[b][p] = mi[b][p-1]; end
        md[b][0] = d; mi[b][0] = id; mn[b]++;
    endtask

    task automatic pop_front(int b, output logic [7:0] d, output int id);
        d = md[b][0]; id = mi[b][0];
        for (int p = 0; p < mn[b] - 1; p++) begin md[b][p] = md[b][p+1]; mi[b][p] = mi[b][p+1]; end
        mn[b]--;
    endtask

    task automatic remove_id(int id);
        for (int b = 0; b < NC; b++)
            for (int p = 0; p < mn[b]; p++)
                if (mi[b][p] == id) begin
                    for (int q = p; q < mn[b] - 1; q++) begin md[b][q] = md[b][q+1]; mi[b][q] = mi[b][q+1]; end
                    mn[b]--;
                    return;
                end
    endtask

    task automatic m_step(bit av, int ac, logic [7:0] ad, logic [NC-1:1] pr, bit dr);
        int c, t, hid, h, did;
        logic [7:0] dd;
        logic [NC-1:0] g;
        bit fire;
        ev_viol = '0; ev_drop = 0; ev_adm = 0; ev_admc = 0;
        h = mfirst();
        fire = dr && (h >= 0);
        hid = fire ? mi[h][0] : -1;
        c = (ac > NC - 1) ? NC - 1 : ac;
        if (av) begin
            t = -1;
            for (int i = c; i < NC; i++)
                if (t < 0) begin
                    if (mcum(i) < lim(i)) t = i;
                    else ev_viol[i] = 1'b1;
                end
            if (t < 0) ev_drop = 1;
            else begin
                for (int j = NC - 1; j > t; j--)
                    if (mcum(j) == lim(j)) begin
                        ev_viol[j] = 1'b1;
                        if (j == NC - 1) begin mn[j]--; ev_drop = 1; end
                        else begin
                            dd = md[j][mn[j]-1]; did = mi[j][mn[j]-1]; mn[j]--;
                            push_front(j + 1, dd, did);
                        end
                    end
                push_back(t, ad, next_id); next_id++;
                ev_adm = (t == c); ev_admc = c;
            end
        end
        mpend = mpend | {pr, 1'b0};
        g = '0;
        for (int i = 1; i < NC; i++)
            g[i] = mpend[i] && (mn[i] > 0) && (mcum(i - 1) < lim(i - 1));
        for (int i = 1; i < NC; i++)
            if (g[i]) begin pop_front(i, dd, did); push_back(i - 1, dd, did); end
        mpend = mpend & ~g;
        if (fire) remove_id(hid);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int h = mfirst();
        chk("R7", "deq_valid", int'(deq_valid), int'(h >= 0));
        if (h >= 0) begin
            chk("R7 R8", "deq_data", int'(deq_data), int'(md[h][0]));
            chk("R6 R7", "deq_class", int'(deq_class), h);
        end
        chk("R3 R4 R9", "viol", int'(viol), int'(ev_viol));
        chk("R5 R9", "drop", int'(drop), int'(ev_drop));
        chk("R2 R9", "adm_valid", int'(adm_valid), int'(ev_adm));
        if (ev_adm) chk("R9", "adm_class", int'(adm_class), ev_admc);
    endtask

    task automatic cycle(bit av, int ac, logic [7:0] ad, logic [NC-1:1] pr, bit dr);
        arr_valid = av; arr_class = ac[1:0]; arr_data = ad; promo_req = pr; deq_ready = dr;
        m_step(av, ac, ad, pr, dr);
        @(negedge clk);
        compare_all();
    endtask

    task automatic drain();
        while (mfirst() >= 0) cycle(0, 0, 8'h00, '0, 1);
        cycle(0, 0, 8'h00, '0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NC; b++) mn[b] = 0;
        mpend = '0; next_id = 1;
        ev_viol = '0; ev_drop = 0; ev_adm = 0; ev_admc = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "deq_valid in reset", int'(deq_valid), 0);
        chk("R1", "viol in reset", int'(viol), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "deq_valid after reset", int'(deq_valid), 0);
        chk("R1", "adm/drop after reset", int'({adm_valid, drop}), 0);

        // R2 out-of-range class lands in the lowest buffer
        cycle(1, 3, 8'h3C, '0, 0);
        chk("R2", "class 3 buffer", int'(deq_class), 2);
        chk("R2", "class 3 admitted", int'(adm_valid), 1);
        drain();

        // R3 level 0 full, arrival falls to buffer 1
        for (int k = 0; k < 6; k++) cycle(1, 0, 8'(8'h10 + k), '0, 0);
        cycle(1, 0, 8'h77, '0, 0);
        chk("R3", "overflow viol", int'(viol), 3'b001);
        chk("R3", "overflow not admitted", int'(adm_valid), 0);
        drain();

        // R4 push-out of last entry of buffer 1
        for (int k = 0; k < 6; k++) cycle(1, 0, 8'(8'h20 + k), '0, 0);
        for (int k = 0; k < 6; k++) cycle(1, 1, 8'(8'h30 + k), '0, 0);
        cycle(0, 0, 8'h00, '0, 1);
        cycle(1, 1, 8'h36, '0, 0);
        cycle(1, 0, 8'hAA, '0, 0);
        chk("R4", "push-out viol", int'(viol), 3'b010);
        chk("R4", "push-out admits class 0", int'(adm_valid), 1);
        drain();

        // R6 deferred promotion until level 0 has room
        for (int k = 0; k < 6; k++) cycle(1, 0, 8'(8'h40 + k), '0, 0);
        cycle(1, 1, 8'h50, '0, 0);
        cycle(1, 1, 8'h51, '0, 0);
        cycle(0, 0, 8'h00, 2'b01, 0);
        cycle(0, 0, 8'h00, '0, 1);
        for (int k = 0; k < 5; k++) cycle(0, 0, 8'h00, '0, 1);
        chk("R6", "promoted head data", int'(deq_data), 8'h50);
        chk("R6", "promoted head class", int'(deq_class), 0);
        drain();

        // R5 all levels full, arrival dropped
        for (int k = 0; k < DP; k++) cycle(1, 2, 8'(k), '0, 0);
        cycle(1, 2, 8'hEE, '0, 0);
        chk("R5", "drop when full", int'(drop), 1);
        chk("R5", "drop viol", int'(viol), 3'b100);
        drain();

        // R8 insertion ahead of the presented entry in the dequeue cycle
        cycle(1, 2, 8'h55, '0, 0);
        cycle(1, 0, 8'h66, '0, 1);
        chk("R8", "head after same-cycle arrival", int'(deq_data), 8'h66);
        chk("R8", "class after same-cycle arrival", int'(deq_class), 0);
        drain();

        // random phases: fill-heavy and drain-heavy
        for (int ph = 0; ph < 10; ph++) begin
            for (int n = 0; n < 400; n++) begin
                bit av, dr;
                logic [NC-1:1] pr;
                av = ($urandom % 100) < ((ph % 2 == 0) ? 85 : 35);
                dr = ($urandom % 100) < ((ph % 2 == 0) ? 20 : 80);
                pr = '0;
                for (int i = 1; i < NC; i++) pr[i] = ($urandom % 100) < 20;
                cycle(av, int'($urandom % 4), 8'($urandom), pr, dr);
            end
        end
        drain();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule